// File: doc/BRIEF.md
# Flash Memory Controller with Erase Sequencer

This block fronts an on-chip NOR-style flash array and a small bank of user-configuration words. A 32-bit register port holds an enable register and a ready flag, and takes erase commands. A separate word-wide flash port reads the array and programs it. A third word-wide port reads and writes the user-configuration bank directly. All accesses are whole 32-bit words, and byte 0 of a word sits at its lowest address. Programming can only pull bits low, so a word returns to all ones only through an erase.

Erases run in a sequencer that stores all ones into one word per clock. A page erase covers one page. Erase-all covers the whole flash and, in the same pass, the user bank. A user-bank erase covers only the user words. Erase-all and user-bank erase run only when the written value matches a key. While the sequencer runs, reads still work. Every write on any port is dropped and reported. Permission faults, bad register offsets and busy collisions each raise a one-cycle error pulse.

Top module: `nvm_ctrl`

## Requirements
- R1: The enable register at offset 0x504 keeps only bit 0 (program enable) and bit 1 (erase enable). Every other bit reads as zero, and the register resets to 0.
- R2: The ready register at offset 0x400 reads 1 when idle and 0 while an erase runs. An erase stores one word per clock, so it holds ready low for exactly as many cycles as it has words: a page, the whole flash, or the user bank.
- R3: A flash-port write with program enable set replaces the addressed word with the old word ANDed with the written data.
- R4: A flash-port write with program enable clear leaves the array unchanged. In the cycle after the write, err_wr_lock_o is 1.
- R5: Writing either page-erase register (0x510 or 0x508) with erase enable set clears the in-page offset bits of the written byte address and fills that page with 0xFFFFFFFF. All other pages keep their contents.
- R6: A page erase whose aligned address is above FLASH_BYTES minus PAGE_BYTES changes nothing and never drops ready. A page erase with erase enable clear changes nothing and pulses err_ers_lock_o in the next cycle.
- R7: Writing the key value 0x00000001 to the erase-all register at 0x50C, with erase enable set, fills every flash word and every user word with all ones. Any other value has no effect.
- R8: The key written to the erase-all register while erase enable is clear changes nothing, leaves ready at 1, and pulses err_ers_lock_o in the next cycle.
- R9: Writing the key to the user-erase register at 0x514 fills every user word with all ones, whatever erase enable holds. Flash is untouched, and any other value has no effect.
- R10: After reset, every user word reads 0xFFFFFFFF, the enable register reads 0 and ready reads 1.
- R11: A read of any register offset other than 0x400 or 0x504 returns 0. A write to any offset other than 0x504, 0x508, 0x50C, 0x510 or 0x514 changes nothing. Writes to 0x400 are in this group. In both cases err_bad_off_o is 1 in the next cycle.
- R12: While an erase runs, every write on the register, flash and user ports is dropped, and err_busy_o is 1 in the next cycle.
- R13: When idle, a user-port write stores the data word as written, with no enable needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Register write (1) or read (0) |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the request cycle |
| fl_req_i | input | 1 | Flash access request |
| fl_we_i | input | 1 | Flash program (1) or read (0) |
| fl_addr_i | input | FL_AW | Flash byte address, word aligned |
| fl_wdata_i | input | 32 | Flash program data |
| fl_rdata_o | output | 32 | Flash word at fl_addr_i |
| uc_req_i | input | 1 | User bank access request |
| uc_we_i | input | 1 | User bank write (1) or read (0) |
| uc_addr_i | input | UC_AW | User word index |
| uc_wdata_i | input | 32 | User bank write data |
| uc_rdata_o | output | 32 | User word at uc_addr_i |
| err_wr_lock_o | output | 1 | Pulse: flash program refused |
| err_ers_lock_o | output | 1 | Pulse: erase refused, erase enable clear |
| err_bad_off_o | output | 1 | Pulse: unknown register offset |
| err_busy_o | output | 1 | Pulse: write dropped during erase |

## Verification
The assertions assume that no port holds X once reset is released, and that a register request describes one complete word access per cycle. Their window checks also assume that each error pulse can be traced to the access made one cycle earlier. The bench drives each port on its own, one access per call, from the falling edge, so every request is held for exactly one rising edge. It always deasserts the request before the next access. Flash addresses are whole word indices multiplied by four. The random flash traffic toggles the enables only through legal writes to the enable register, so the checks always reason about known permission state.

// File: rtl/nvm_ctrl_pkg.sv
`timescale 1ns/1ps
package nvm_ctrl_pkg;
  localparam logic [11:0] OFF_READY      = 12'h400;
  localparam logic [11:0] OFF_CFG        = 12'h504;
  localparam logic [11:0] OFF_PGERASE_B  = 12'h508;
  localparam logic [11:0] OFF_ERASE_ALL  = 12'h50C;
  localparam logic [11:0] OFF_PGERASE_A  = 12'h510;
  localparam logic [11:0] OFF_ERASE_UCFG = 12'h514;
  localparam logic [31:0] ERASE_KEY      = 32'h0000_0001;
  localparam int unsigned CFG_WEN_BIT    = 0;
  localparam int unsigned CFG_EEN_BIT    = 1;

  typedef enum logic [1:0] {
    ERS_NONE = 2'd0,
    ERS_PAGE = 2'd1,
    ERS_ALL  = 2'd2,
    ERS_UCFG = 2'd3
  } erase_op_e;
endpackage

// File: rtl/nvm_cfg_regs.sv
`timescale 1ns/1ps
module nvm_cfg_regs
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned FLASH_BYTES = 8192,
  parameter int unsigned PAGE_BYTES  = 1024,
  parameter int unsigned PG_IDX_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_req_i,
  input  logic                reg_we_i,
  input  logic [11:0]         reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic                busy_i,
  input  logic                fl_wr_i,
  input  logic                uc_wr_i,
  output logic                cfg_wen_o,
  output logic                cfg_een_o,
  output erase_op_e           start_op_o,
  output logic [PG_IDX_W-1:0] start_page_o,
  output logic                err_wr_lock_o,
  output logic                err_ers_lock_o,
  output logic                err_bad_off_o,
  output logic                err_busy_o
);
  localparam int unsigned NUM_PAGES = FLASH_BYTES / PAGE_BYTES;
  localparam int unsigned PG_SH     = $clog2(PAGE_BYTES);

  logic [1:0]  cfg_q;
  logic        wr, rd, accept;
  logic        cfg_we, lock_d, known_wr, known_rd, key_ok, in_range;
  logic [31:0] page_hi, rdata;

  assign wr       = reg_req_i & reg_we_i;
  assign rd       = reg_req_i & ~reg_we_i;
  assign accept   = wr & ~busy_i;
  assign key_ok   = (reg_wdata_i == ERASE_KEY);
  assign page_hi  = reg_wdata_i >> PG_SH;
  assign in_range = (page_hi < NUM_PAGES);
  assign start_page_o = page_hi[PG_IDX_W-1:0];

  always_comb begin
    start_op_o = ERS_NONE;
    lock_d     = 1'b0;
    cfg_we     = 1'b0;
    known_wr   = 1'b1;
    case (reg_addr_i)
      OFF_CFG: cfg_we = 1'b1;
      OFF_PGERASE_A, OFF_PGERASE_B: begin
        if (cfg_q[CFG_EEN_BIT]) begin
          if (in_range) start_op_o = ERS_PAGE;
        end else begin
          lock_d = 1'b1;
        end
      end
      OFF_ERASE_ALL: begin
        if (key_ok) begin
          if (cfg_q[CFG_EEN_BIT]) start_op_o = ERS_ALL;
          else                    lock_d     = 1'b1;
        end
      end
      OFF_ERASE_UCFG: if (key_ok) start_op_o = ERS_UCFG;
      default: known_wr = 1'b0;
    endcase
    if (!accept) begin
      start_op_o = ERS_NONE;
      lock_d     = 1'b0;
      cfg_we     = 1'b0;
    end
  end

  always_comb begin
    rdata    = '0;
    known_rd = 1'b1;
    case (reg_addr_i)
      OFF_READY: rdata[0]   = ~busy_i;
      OFF_CFG:   rdata[1:0] = cfg_q;
      default:   known_rd   = 1'b0;
    endcase
  end
  assign reg_rdata_o = rd ? rdata : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q          <= '0;
      err_wr_lock_o  <= 1'b0;
      err_ers_lock_o <= 1'b0;
      err_bad_off_o  <= 1'b0;
      err_busy_o     <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= reg_wdata_i[1:0];
      err_wr_lock_o  <= fl_wr_i & ~busy_i & ~cfg_q[CFG_WEN_BIT];
      err_ers_lock_o <= lock_d;
      err_bad_off_o  <= (rd & ~known_rd) | (accept & ~known_wr);
      err_busy_o     <= busy_i & (wr | fl_wr_i | uc_wr_i);
    end
  end

  assign cfg_wen_o = cfg_q[CFG_WEN_BIT];
  assign cfg_een_o = cfg_q[CFG_EEN_BIT];
endmodule

// File: rtl/nvm_erase_seq.sv
`timescale 1ns/1ps
module nvm_erase_seq
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned FLASH_WORDS = 2048,
  parameter int unsigned PAGE_WORDS  = 256,
  parameter int unsigned UCFG_WORDS  = 64,
  parameter int unsigned PG_IDX_W    = 3,
  localparam int unsigned FW_AW      = $clog2(FLASH_WORDS),
  localparam int unsigned UC_AW      = $clog2(UCFG_WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  erase_op_e           start_op_i,
  input  logic [PG_IDX_W-1:0] start_page_i,
  output logic                busy_o,
  output logic                fl_ers_o,
  output logic [FW_AW-1:0]    fl_ers_idx_o,
  output logic                uc_ers_o,
  output logic [UC_AW-1:0]    uc_ers_idx_o
);
  localparam int unsigned PW_SH = $clog2(PAGE_WORDS);
  localparam logic [FW_AW-1:0] LAST_PG = FW_AW'(PAGE_WORDS - 1);
  localparam logic [FW_AW-1:0] LAST_FL = FW_AW'(FLASH_WORDS - 1);
  localparam logic [FW_AW-1:0] LAST_UC = FW_AW'(UCFG_WORDS - 1);
  localparam logic [FW_AW:0]   UC_LIM  = (FW_AW+1)'(UCFG_WORDS);

  erase_op_e        op_q;
  logic [FW_AW-1:0] cnt_q, base_q;
  logic             last;

  always_comb begin
    case (op_q)
      ERS_PAGE: last = (cnt_q == LAST_PG);
      ERS_ALL:  last = (cnt_q == LAST_FL);
      ERS_UCFG: last = (cnt_q == LAST_UC);
      default:  last = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= ERS_NONE;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (op_q == ERS_NONE) begin
      if (start_op_i != ERS_NONE) begin
        op_q   <= start_op_i;
        cnt_q  <= '0;
        base_q <= (start_op_i == ERS_PAGE) ? {start_page_i, {PW_SH{1'b0}}} : '0;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (last) op_q <= ERS_NONE;
    end
  end

  assign busy_o       = (op_q != ERS_NONE);
  assign fl_ers_o     = (op_q == ERS_PAGE) | (op_q == ERS_ALL);
  assign fl_ers_idx_o = base_q + cnt_q;
  assign uc_ers_o     = (op_q == ERS_UCFG) | ((op_q == ERS_ALL) & ({1'b0, cnt_q} < UC_LIM));
  assign uc_ers_idx_o = cnt_q[UC_AW-1:0];
endmodule

// File: rtl/nvm_flash_array.sv
`timescale 1ns/1ps
module nvm_flash_array #(
  parameter int unsigned WORDS = 2048,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [31:0]   wr_data_i,
  input  logic          ers_i,
  input  logic [AW-1:0] ers_idx_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [31:0]   rd_data_o
);
  logic [31:0] mem_q [WORDS];

  // non-volatile: no reset; programming only clears bits
  always_ff @(posedge clk_i) begin
    if (ers_i)     mem_q[ers_idx_i] <= '1;
    else if (wr_i) mem_q[wr_idx_i]  <= mem_q[wr_idx_i] & wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/nvm_ucfg_array.sv
`timescale 1ns/1ps
module nvm_ucfg_array #(
  parameter int unsigned WORDS = 64,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [31:0]   wr_data_i,
  input  logic          ers_i,
  input  logic [AW-1:0] ers_idx_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [31:0]   rd_data_o
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(WORDS); i++) mem_q[i] <= '1;
    end else if (ers_i) begin
      mem_q[ers_idx_i] <= '1;
    end else if (wr_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/nvm_ctrl.sv
`timescale 1ns/1ps
module nvm_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned FLASH_BYTES = 8192,
  parameter int unsigned PAGE_BYTES  = 1024,
  parameter int unsigned UCFG_WORDS  = 64,
  localparam int unsigned FL_AW      = $clog2(FLASH_BYTES),
  localparam int unsigned UC_AW      = $clog2(UCFG_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_req_i,
  input  logic             reg_we_i,
  input  logic [11:0]      reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic             fl_req_i,
  input  logic             fl_we_i,
  input  logic [FL_AW-1:0] fl_addr_i,
  input  logic [31:0]      fl_wdata_i,
  output logic [31:0]      fl_rdata_o,
  input  logic             uc_req_i,
  input  logic             uc_we_i,
  input  logic [UC_AW-1:0] uc_addr_i,
  input  logic [31:0]      uc_wdata_i,
  output logic [31:0]      uc_rdata_o,
  output logic             err_wr_lock_o,
  output logic             err_ers_lock_o,
  output logic             err_bad_off_o,
  output logic             err_busy_o
);
  localparam int unsigned FLASH_WORDS = FLASH_BYTES / 4;
  localparam int unsigned PAGE_WORDS  = PAGE_BYTES / 4;
  localparam int unsigned NUM_PAGES   = FLASH_BYTES / PAGE_BYTES;
  localparam int unsigned PG_IDX_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int unsigned FW_AW       = $clog2(FLASH_WORDS);

  logic                busy, cfg_wen, cfg_een;
  logic                fl_wr, uc_wr;
  erase_op_e           start_op;
  logic [PG_IDX_W-1:0] start_page;
  logic                fl_ers, uc_ers;
  logic [FW_AW-1:0]    fl_ers_idx, fl_idx;
  logic [UC_AW-1:0]    uc_ers_idx;
  logic                unused_addr_lsb;

  assign fl_wr  = fl_req_i & fl_we_i;
  assign uc_wr  = uc_req_i & uc_we_i;
  assign fl_idx = fl_addr_i[FL_AW-1:2];
  assign unused_addr_lsb = ^fl_addr_i[1:0];

  nvm_cfg_regs #(
    .FLASH_BYTES(FLASH_BYTES), .PAGE_BYTES(PAGE_BYTES), .PG_IDX_W(PG_IDX_W)
  ) u_regs (
    .clk_i, .rst_ni, .reg_req_i, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .fl_wr_i(fl_wr), .uc_wr_i(uc_wr),
    .cfg_wen_o(cfg_wen), .cfg_een_o(cfg_een),
    .start_op_o(start_op), .start_page_o(start_page),
    .err_wr_lock_o, .err_ers_lock_o, .err_bad_off_o, .err_busy_o
  );

  nvm_erase_seq #(
    .FLASH_WORDS(FLASH_WORDS), .PAGE_WORDS(PAGE_WORDS),
    .UCFG_WORDS(UCFG_WORDS), .PG_IDX_W(PG_IDX_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_op_i(start_op), .start_page_i(start_page),
    .busy_o(busy), .fl_ers_o(fl_ers), .fl_ers_idx_o(fl_ers_idx),
    .uc_ers_o(uc_ers), .uc_ers_idx_o(uc_ers_idx)
  );

  nvm_flash_array #(.WORDS(FLASH_WORDS)) u_flash (
    .clk_i,
    .wr_i(fl_wr & ~busy & cfg_wen), .wr_idx_i(fl_idx), .wr_data_i(fl_wdata_i),
    .ers_i(fl_ers), .ers_idx_i(fl_ers_idx),
    .rd_idx_i(fl_idx), .rd_data_o(fl_rdata_o)
  );

  nvm_ucfg_array #(.WORDS(UCFG_WORDS)) u_ucfg (
    .clk_i, .rst_ni,
    .wr_i(uc_wr & ~busy), .wr_idx_i(uc_addr_i), .wr_data_i(uc_wdata_i),
    .ers_i(uc_ers), .ers_idx_i(uc_ers_idx),
    .rd_idx_i(uc_addr_i), .rd_data_o(uc_rdata_o)
  );
endmodule

// File: rtl/nvm_ctrl_chk.sv
`timescale 1ns/1ps
module nvm_ctrl_chk
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned FLASH_BYTES = 8192,
  parameter int unsigned PAGE_BYTES  = 1024
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_req_i,
  input logic        reg_we_i,
  input logic [11:0] reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        fl_req_i,
  input logic        fl_we_i,
  input logic        busy_i,
  input logic        wen_i,
  input logic        een_i,
  input logic        err_wr_lock_o,
  input logic        err_ers_lock_o,
  input logic        err_bad_off_o,
  input logic        err_busy_o
);
  logic rd, wr, fwr, known_rd, pg_wr, far_page;
  assign rd       = reg_req_i & ~reg_we_i;
  assign wr       = reg_req_i & reg_we_i;
  assign fwr      = fl_req_i & fl_we_i;
  assign known_rd = (reg_addr_i == OFF_READY) || (reg_addr_i == OFF_CFG);
  assign pg_wr    = wr && ((reg_addr_i == OFF_PGERASE_A) || (reg_addr_i == OFF_PGERASE_B));
  assign far_page = (reg_wdata_i / PAGE_BYTES) >= (FLASH_BYTES / PAGE_BYTES);

  // R1
  cfg_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && reg_addr_i == OFF_CFG) |-> reg_rdata_o[31:2] == '0);

  // R2
  ready_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && reg_addr_i == OFF_READY && busy_i) |-> reg_rdata_o == '0);

  // R4
  wr_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwr && !busy_i && !wen_i) |=> err_wr_lock_o);

  // R6
  far_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_wr && een_i && far_page && !busy_i) |=> !busy_i);

  // R8
  all_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_addr_i == OFF_ERASE_ALL && reg_wdata_i == ERASE_KEY && !een_i && !busy_i)
    |=> (err_ers_lock_o && !busy_i));

  // R9
  ucfg_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_addr_i == OFF_ERASE_UCFG && reg_wdata_i == ERASE_KEY && !busy_i) |=> busy_i);

  // R11
  bad_rd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !known_rd) |-> reg_rdata_o == '0);

  // R11
  bad_rd_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !known_rd) |=> err_bad_off_o);

  // R12
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (fwr || wr)) |=> err_busy_o);
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.FLASH_BYTES(FLASH_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .fl_req_i(fl_req_i), .fl_we_i(fl_we_i),
  .busy_i(busy), .wen_i(cfg_wen), .een_i(cfg_een),
  .err_wr_lock_o(err_wr_lock_o), .err_ers_lock_o(err_ers_lock_o),
  .err_bad_off_o(err_bad_off_o), .err_busy_o(err_busy_o)
);

// File: tb/nvm_ctrl_bench.sv
`timescale 1ns/1ps
module nvm_ctrl_bench;
  localparam int FB = 512;
  localparam int PB = 64;
  localparam int UW = 16;
  localparam int FW = FB / 4;
  localparam int PW = PB / 4;
  localparam int FL_AW = $clog2(FB);
  localparam int UC_AW = $clog2(UW);

  localparam logic [11:0] A_READY = 12'h400, A_CFG = 12'h504, A_PGB = 12'h508,
                          A_ALL = 12'h50C, A_PGA = 12'h510, A_UCE = 12'h514;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_req = 0, reg_we = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic fl_req = 0, fl_we = 0;
  logic [FL_AW-1:0] fl_addr = '0;
  logic [31:0] fl_wdata = '0, fl_rdata;
  logic uc_req = 0, uc_we = 0;
  logic [UC_AW-1:0] uc_addr = '0;
  logic [31:0] uc_wdata = '0, uc_rdata;
  logic e_wr, e_ers, e_bad, e_busy;

  logic [31:0] exp_fl [FW];
  logic [31:0] exp_uc [UW];
  logic [1:0]  exp_cfg;
  int total = 0, fails = 0;
  logic [31:0] rv;
  int n;

  always #10 clk = ~clk;

  nvm_ctrl #(.FLASH_BYTES(FB), .PAGE_BYTES(PB), .UCFG_WORDS(UW)) u_nvm_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .fl_req_i(fl_req), .fl_we_i(fl_we), .fl_addr_i(fl_addr),
    .fl_wdata_i(fl_wdata), .fl_rdata_o(fl_rdata),
    .uc_req_i(uc_req), .uc_we_i(uc_we), .uc_addr_i(uc_addr),
    .uc_wdata_i(uc_wdata), .uc_rdata_o(uc_rdata),
    .err_wr_lock_o(e_wr), .err_ers_lock_o(e_ers),
    .err_bad_off_o(e_bad), .err_busy_o(e_busy)
  );

  function automatic logic [31:0] prog_word(logic [31:0] old_w, logic [31:0] d);
    return old_w & d;
  endfunction

  function automatic int page_first_word(logic [31:0] byte_addr);
    return int'(byte_addr / PB) * PW;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #5;
    reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #5;
    reg_req = 0;
  endtask

  task automatic fl_write(input int w, input logic [31:0] d);
    @(negedge clk);
    fl_req = 1; fl_we = 1; fl_addr = FL_AW'(w * 4); fl_wdata = d;
    @(posedge clk); #5;
    fl_req = 0; fl_we = 0;
  endtask

  task automatic uc_write(input int w, input logic [31:0] d);
    @(negedge clk);
    uc_req = 1; uc_we = 1; uc_addr = UC_AW'(w); uc_wdata = d;
    @(posedge clk); #5;
    uc_req = 0; uc_we = 0;
  endtask

  task automatic wait_idle(output int zeros);
    logic [31:0] r;
    zeros = 0;
    for (int k = 0; k < 1000; k++) begin
      reg_read(A_READY, r);
      if (r[0]) break;
      zeros++;
    end
  endtask

  task automatic cmp_flash(input string req);
    int bad = 0;
    for (int i = 0; i < FW; i++) begin
      @(negedge clk);
      fl_addr = FL_AW'(i * 4);
      #1 if (fl_rdata !== exp_fl[i]) bad++;
    end
    chk(bad == 0, req, 32'(bad), 32'd0);
  endtask

  task automatic cmp_ucfg(input string req);
    int bad = 0;
    for (int i = 0; i < UW; i++) begin
      @(negedge clk);
      uc_addr = UC_AW'(i);
      #1 if (uc_rdata !== exp_uc[i]) bad++;
    end
    chk(bad == 0, req, 32'(bad), 32'd0);
  endtask

  task automatic fill_ucfg_random();
    for (int i = 0; i < UW; i++) begin
      exp_uc[i] = $urandom;
      uc_write(i, exp_uc[i]);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL R2 watchdog expired, erase or bench hung");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    exp_cfg = 2'b00;
    for (int i = 0; i < UW; i++) exp_uc[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10, R1 reset state
    reg_read(A_CFG, rv);   chk(rv == 32'd0, "R10 cfg reset", rv, 32'd0);
    reg_read(A_READY, rv); chk(rv == 32'd1, "R10 ready reset", rv, 32'd1);
    cmp_ucfg("R10 user words reset");

    // R1 only bits 1:0 kept
    reg_write(A_CFG, 32'hFFFF_FFFF);
    reg_read(A_CFG, rv);   chk(rv == 32'd3, "R1 cfg mask", rv, 32'd3);
    reg_write(A_CFG, 32'hA5A5_A5A4);
    reg_read(A_CFG, rv);   chk(rv == 32'd0, "R1 cfg mask low", rv, 32'd0);

    // R13 user port writes
    fill_ucfg_random();
    cmp_ucfg("R13 user write");

    // R8 key without erase enable
    reg_write(A_ALL, 32'd1);
    chk(e_ers == 1'b1, "R8 lock flag", 32'(e_ers), 32'd1);
    reg_read(A_READY, rv); chk(rv == 32'd1, "R8 ready stays", rv, 32'd1);
    cmp_ucfg("R8 user unchanged");

    // R7 wrong key
    reg_write(A_CFG, 32'd2); exp_cfg = 2'b10;
    reg_write(A_ALL, 32'd2);
    reg_read(A_READY, rv); chk(rv == 32'd1, "R7 bad key ignored", rv, 32'd1);
    cmp_ucfg("R7 bad key user unchanged");

    // R7, R2 full erase
    reg_write(A_ALL, 32'd1);
    wait_idle(n);
    chk(n == FW, "R2 erase-all cycles", 32'(n), 32'(FW));
    for (int i = 0; i < FW; i++) exp_fl[i] = '1;
    for (int i = 0; i < UW; i++) exp_uc[i] = '1;
    cmp_flash("R7 flash all ones");
    cmp_ucfg("R7 user all ones");

    // R9 user erase with enables clear
    fill_ucfg_random();
    reg_write(A_CFG, 32'd0); exp_cfg = 2'b00;
    reg_write(A_UCE, 32'd5);
    reg_read(A_READY, rv); chk(rv == 32'd1, "R9 bad key ignored", rv, 32'd1);
    cmp_ucfg("R9 bad key user unchanged");
    reg_write(A_UCE, 32'd1);
    wait_idle(n);
    chk(n == UW, "R2 user erase cycles", 32'(n), 32'(UW));
    for (int i = 0; i < UW; i++) exp_uc[i] = '1;
    cmp_ucfg("R9 user all ones");
    cmp_flash("R9 flash untouched");

    // R3, R4 random programming
    for (int it = 0; it < 300; it++) begin
      int w;
      logic [31:0] d;
      if ($urandom % 8 == 0) begin
        exp_cfg = 2'($urandom);
        reg_write(A_CFG, {$urandom, 2'b00} | 32'(exp_cfg));
      end
      w = int'($urandom % FW);
      d = ($urandom % 2 == 0) ? ($urandom | $urandom) : $urandom;
      fl_write(w, d);
      if (exp_cfg[0]) begin
        exp_fl[w] = prog_word(exp_fl[w], d);
        if (e_wr !== 1'b0) chk(1'b0, "R3 no lock flag", 32'(e_wr), 32'd0);
      end else begin
        if (e_wr !== 1'b1) chk(1'b0, "R4 lock flag", 32'(e_wr), 32'd1);
      end
    end
    chk(1'b1, "R4 lock flag sweep", 32'd0, 32'd0);
    cmp_flash("R3 R4 programmed contents");

    // R5 page erase through both registers, offset bits ignored
    reg_write(A_CFG, 32'd3); exp_cfg = 2'b11;
    fl_write(0, 32'h0); exp_fl[0] = 32'h0;
    reg_write(A_PGA, 32'(3 * PB + 36));
    wait_idle(n);
    chk(n == PW, "R2 page erase cycles", 32'(n), 32'(PW));
    for (int i = 0; i < PW; i++) exp_fl[page_first_word(32'(3 * PB)) + i] = '1;
    cmp_flash("R5 page 3 via first register");
    reg_write(A_PGB, 32'(FB - PB + 60));
    wait_idle(n);
    for (int i = 0; i < PW; i++) exp_fl[page_first_word(32'(FB - PB)) + i] = '1;
    cmp_flash("R5 last page via second register");

    // R6 out of range, and erase enable clear
    reg_write(A_PGA, 32'(FB));
    reg_read(A_READY, rv); chk(rv == 32'd1, "R6 far page no busy", rv, 32'd1);
    reg_write(A_CFG, 32'd1); exp_cfg = 2'b01;
    reg_write(A_PGB, 32'd0);
    chk(e_ers == 1'b1, "R6 lock flag", 32'(e_ers), 32'd1);
    cmp_flash("R6 flash unchanged");

    // R11 bad offsets
    reg_read(12'h008, rv); chk(rv == 32'd0, "R11 bad read data", rv, 32'd0);
    chk(e_bad == 1'b1, "R11 bad read flag", 32'(e_bad), 32'd1);
    reg_read(A_ALL, rv);   chk(e_bad == 1'b1, "R11 erase reg not readable", 32'(e_bad), 32'd1);
    reg_write(A_READY, 32'd0);
    chk(e_bad == 1'b1, "R11 ready write flag", 32'(e_bad), 32'd1);
    reg_write(12'h700, 32'd3);
    chk(e_bad == 1'b1, "R11 unknown write flag", 32'(e_bad), 32'd1);
    reg_read(A_CFG, rv);   chk(rv == 32'(exp_cfg), "R11 cfg unchanged", rv, 32'(exp_cfg));

    // R12 writes during erase
    reg_write(A_CFG, 32'd3); exp_cfg = 2'b11;
    fill_ucfg_random();
    reg_write(A_PGA, 32'(PB));
    fl_write(2, 32'h0);
    chk(e_busy == 1'b1, "R12 flash write busy", 32'(e_busy), 32'd1);
    reg_write(A_CFG, 32'd0);
    chk(e_busy == 1'b1, "R12 reg write busy", 32'(e_busy), 32'd1);
    uc_write(1, 32'h1234_5678);
    chk(e_busy == 1'b1, "R12 user write busy", 32'(e_busy), 32'd1);
    wait_idle(n);
    for (int i = 0; i < PW; i++) exp_fl[PW + i] = '1;
    reg_read(A_CFG, rv);   chk(rv == 32'd3, "R12 cfg kept", rv, 32'd3);
    cmp_flash("R12 flash unchanged by dropped write");
    cmp_ucfg("R12 user unchanged by dropped write");

    report();
    $finish;
  end
endmodule